// File: doc/BRIEF.md
# Transaction Checkpoint and Nesting Controller

This block sits beside the rename stage of a small out-of-order core model and gives it flattened transactional nesting. Begin and end commands move a nesting counter up and down. The outermost begin records one abort handler address and copies the rename table into a single snapshot. The same begin flags every physical register then in the map as saved. Inner begins only count, so however deep the nesting goes there is one checkpoint.

The block also owns the physical register pool. A rename request takes the lowest-numbered free physical register and writes it into the map. When an overwritten physical register graduates, it is freed unless it is flagged saved. A saved register is parked on a reserved list, so the checkpointed architectural state is never reused while a transaction is open. The outermost end commits: reserved registers go back to the free list and all saved flags clear. An abort at any depth restores the map from the snapshot, returns every register outside the restored map to the free list, and presents the handler address as a one-cycle redirect.

Top module: `txn_ckpt_ctrl`

## Requirements
- R1: After reset the nesting depth is 0, architectural register i maps to physical register i, physical registers ARCH_REGS and above are free, the reserved and saved vectors are all zero, and neither redirect_valid nor cmd_err is set.
- R2: alloc_avail is high exactly when some free bit is set, and alloc_phys is then the index of the lowest set free bit. A rename (ren_valid) with alloc_avail writes alloc_phys into map entry ren_arch and clears that free bit at the next edge. Without a free register, the rename leaves all state unchanged.
- R3: A begin below the maximum depth increases the depth by one. At depth 0 it also stores begin_handler, copies the map into the snapshot, and sets the saved bit of every physical register currently in the map.
- R4: A begin at a depth between 1 and the maximum increases the depth only. The snapshot, the stored handler and the saved vector are unchanged.
- R5: A graduating physical register whose saved bit is set moves onto the reserved list and stays off the free list. A graduating register that is not saved returns to the free list.
- R6: An end at depth 2 or more only decrements the depth. An end at depth 1 sets the depth to 0, ORs the reserved vector into the free vector, and clears the reserved and saved vectors.
- R7: An abort at nonzero depth restores every map entry from the snapshot and sets the depth to 0. The free vector becomes the complement of the set of registers in the restored map, and the reserved and saved vectors clear. In the following cycle only, redirect_valid is high with redirect_pc equal to the handler of the outermost begin.
- R8: An end at depth 0, an abort at depth 0, or a begin at the maximum depth (2^DEPTH_W - 1) changes no state. Each raises cmd_err for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_valid | input | 1 | Begin a (possibly nested) transaction |
| begin_handler | input | ADDR_W | Abort handler address given with the begin |
| end_valid | input | 1 | End the innermost transaction |
| abort_valid | input | 1 | Abort the whole transaction nest |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | log2(ARCH_REGS) | Architectural register being renamed |
| grad_valid | input | 1 | A physical register is released at graduation |
| grad_phys | input | log2(PHYS_REGS) | Physical register being released |
| alloc_avail | output | 1 | At least one physical register is free |
| alloc_phys | output | log2(PHYS_REGS) | Lowest free physical register |
| map_flat | output | ARCH_REGS*log2(PHYS_REGS) | Current rename map, entry i in bits [i*W +: W] |
| free_vec | output | PHYS_REGS | Free list, one bit per physical register |
| resv_vec | output | PHYS_REGS | Reserved list |
| saved_vec | output | PHYS_REGS | Saved flags |
| nest_depth | output | DEPTH_W | Current nesting depth |
| redirect_valid | output | 1 | One-cycle abort redirect |
| redirect_pc | output | ADDR_W | Redirect target (stored handler) |
| cmd_err | output | 1 | One-cycle pulse for an ignored command |

## Verification
The properties assume that at most one of begin, end, abort, rename and graduation is asserted in any cycle. They also assume that a graduating register is neither free, reserved, nor currently mapped: it must be a register that a rename has overwritten and that has not yet graduated. The bench holds to this by choosing a single operation per cycle. It graduates only registers drawn from its own pending set, which it fills on each overwritten mapping and empties on an abort. Random sequences are mixed with directed runs through nesting to full depth, list exhaustion and the ignored commands.

// File: rtl/tcn_pkg.sv
package tcn_pkg;

  // Decoded transaction command, abort has highest priority.
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_ABORT = 2'd1,
    CMD_END   = 2'd2,
    CMD_BEGIN = 2'd3
  } tcn_cmd_e;

  // Events handed from the nesting controller to the storage blocks.
  typedef struct packed {
    logic outer_begin;
    logic commit;
    logic abort_take;
  } tcn_evt_t;

endpackage

// File: rtl/tcn_lowest_set.sv
module tcn_lowest_set #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Scan from the top so the lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/tcn_nest_ctrl.sv
module tcn_nest_ctrl
  import tcn_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_valid,
  input  logic [ADDR_W-1:0] begin_handler,
  input  logic              end_valid,
  input  logic              abort_valid,
  output tcn_evt_t          evt,
  output logic [DEPTH_W-1:0] depth,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              cmd_err
);

  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

  tcn_cmd_e            cmd;
  logic [DEPTH_W-1:0]  depth_q, depth_d;
  logic [ADDR_W-1:0]   handler_q, handler_d;
  logic                handler_en;
  logic                redir_q, redir_d;
  logic                err_q, err_d;

  always_comb begin
    if (abort_valid)      cmd = CMD_ABORT;
    else if (end_valid)   cmd = CMD_END;
    else if (begin_valid) cmd = CMD_BEGIN;
    else                  cmd = CMD_NONE;
  end

  always_comb begin
    depth_d        = depth_q;
    handler_d      = handler_q;
    handler_en     = 1'b0;
    redir_d        = 1'b0;
    err_d          = 1'b0;
    evt            = '0;
    case (cmd)
      CMD_ABORT: begin
        if (depth_q != '0) begin
          evt.abort_take = 1'b1;
          depth_d        = '0;
          redir_d        = 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
      CMD_END: begin
        if (depth_q == '0) begin
          err_d = 1'b1;
        end else begin
          depth_d    = depth_q - 1'b1;
          evt.commit = (depth_q == DEPTH_W'(1));
        end
      end
      CMD_BEGIN: begin
        if (depth_q == DEPTH_MAX) begin
          err_d = 1'b1;
        end else begin
          depth_d = depth_q + 1'b1;
          if (depth_q == '0) begin
            evt.outer_begin = 1'b1;
            handler_d       = begin_handler;
            handler_en      = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      redir_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      redir_q <= redir_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      handler_q <= '0;
    end else if (handler_en) begin
      handler_q <= handler_d;
    end
  end

  assign depth          = depth_q;
  assign redirect_valid = redir_q;
  assign redirect_pc    = handler_q;
  assign cmd_err        = err_q;

endmodule

// File: rtl/tcn_rename_map.sv
module tcn_rename_map #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ren_fire,
  input  logic [AW-1:0]            ren_arch,
  input  logic [PW-1:0]            ren_phys,
  input  logic                     snap_take,
  input  logic                     restore,
  output logic [ARCH_REGS*PW-1:0]  map_flat,
  output logic [PHYS_REGS-1:0]     cur_mask,
  output logic [PHYS_REGS-1:0]     snap_mask
);

  logic [ARCH_REGS-1:0][PW-1:0] map_q, map_d;
  logic [ARCH_REGS-1:0][PW-1:0] snap_q;
  logic                         snap_en;

  always_comb begin
    map_d = map_q;
    if (restore) begin
      map_d = snap_q;
    end else if (ren_fire) begin
      map_d[ren_arch] = ren_phys;
    end
  end

  assign snap_en = snap_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else begin
      map_q <= map_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) snap_q[i] <= PW'(i);
    end else if (snap_en) begin
      snap_q <= map_q;
    end
  end

  // Sets of physical registers referenced by the live map and the snapshot.
  always_comb begin
    cur_mask  = '0;
    snap_mask = '0;
    for (int i = 0; i < ARCH_REGS; i++) begin
      cur_mask[map_q[i]]   = 1'b1;
      snap_mask[snap_q[i]] = 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ARCH_REGS; g++) begin : g_flat
      assign map_flat[g*PW +: PW] = map_q[g];
    end
  endgenerate

endmodule

// File: rtl/tcn_reg_pool.sv
module tcn_reg_pool
  import tcn_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tcn_evt_t             evt,
  input  logic [PHYS_REGS-1:0] cur_mask,
  input  logic [PHYS_REGS-1:0] snap_mask,
  input  logic                 alloc_fire,
  input  logic [PW-1:0]        alloc_idx,
  input  logic                 grad_valid,
  input  logic [PW-1:0]        grad_phys,
  output logic [PHYS_REGS-1:0] free_vec,
  output logic [PHYS_REGS-1:0] resv_vec,
  output logic [PHYS_REGS-1:0] saved_vec
);

  localparam logic [PHYS_REGS-1:0] FREE_RST = {PHYS_REGS{1'b1}} << ARCH_REGS;

  logic [PHYS_REGS-1:0] free_q, free_d;
  logic [PHYS_REGS-1:0] resv_q, resv_d;
  logic [PHYS_REGS-1:0] saved_q, saved_d;

  always_comb begin
    free_d  = free_q;
    resv_d  = resv_q;
    saved_d = saved_q;
    if (evt.abort_take) begin
      free_d  = ~snap_mask;
      resv_d  = '0;
      saved_d = '0;
    end else if (evt.commit) begin
      free_d  = free_q | resv_q;
      resv_d  = '0;
      saved_d = '0;
    end else if (evt.outer_begin) begin
      saved_d = cur_mask;
    end else if (alloc_fire) begin
      free_d[alloc_idx] = 1'b0;
    end else if (grad_valid) begin
      if (saved_q[grad_phys]) resv_d[grad_phys] = 1'b1;
      else                    free_d[grad_phys] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= FREE_RST;
      resv_q  <= '0;
      saved_q <= '0;
    end else begin
      free_q  <= free_d;
      resv_q  <= resv_d;
      saved_q <= saved_d;
    end
  end

  assign free_vec  = free_q;
  assign resv_vec  = resv_q;
  assign saved_vec = saved_q;

endmodule

// File: rtl/txn_ckpt_ctrl.sv
module txn_ckpt_ctrl
  import tcn_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int ADDR_W    = 32,
  parameter int DEPTH_W   = 3,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    begin_valid,
  input  logic [ADDR_W-1:0]       begin_handler,
  input  logic                    end_valid,
  input  logic                    abort_valid,
  input  logic                    ren_valid,
  input  logic [AW-1:0]           ren_arch,
  input  logic                    grad_valid,
  input  logic [PW-1:0]           grad_phys,
  output logic                    alloc_avail,
  output logic [PW-1:0]           alloc_phys,
  output logic [ARCH_REGS*PW-1:0] map_flat,
  output logic [PHYS_REGS-1:0]    free_vec,
  output logic [PHYS_REGS-1:0]    resv_vec,
  output logic [PHYS_REGS-1:0]    saved_vec,
  output logic [DEPTH_W-1:0]      nest_depth,
  output logic                    redirect_valid,
  output logic [ADDR_W-1:0]       redirect_pc,
  output logic                    cmd_err
);

  tcn_evt_t             evt;
  logic [PHYS_REGS-1:0] cur_mask;
  logic [PHYS_REGS-1:0] snap_mask;
  logic                 any_cmd;
  logic                 ren_fire;

  assign any_cmd  = begin_valid | end_valid | abort_valid;
  assign ren_fire = ren_valid & alloc_avail & ~any_cmd;

  tcn_nest_ctrl #(
    .ADDR_W (ADDR_W),
    .DEPTH_W(DEPTH_W)
  ) u_nest (
    .clk           (clk),
    .rst_n         (rst_n),
    .begin_valid   (begin_valid),
    .begin_handler (begin_handler),
    .end_valid     (end_valid),
    .abort_valid   (abort_valid),
    .evt           (evt),
    .depth         (nest_depth),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .cmd_err       (cmd_err)
  );

  tcn_lowest_set #(
    .N(PHYS_REGS)
  ) u_pick (
    .vec  (free_vec),
    .found(alloc_avail),
    .idx  (alloc_phys)
  );

  tcn_rename_map #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .ren_fire (ren_fire),
    .ren_arch (ren_arch),
    .ren_phys (alloc_phys),
    .snap_take(evt.outer_begin),
    .restore  (evt.abort_take),
    .map_flat (map_flat),
    .cur_mask (cur_mask),
    .snap_mask(snap_mask)
  );

  tcn_reg_pool #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS)
  ) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .cur_mask  (cur_mask),
    .snap_mask (snap_mask),
    .alloc_fire(ren_fire),
    .alloc_idx (alloc_phys),
    .grad_valid(grad_valid & ~any_cmd & ~ren_valid),
    .grad_phys (grad_phys),
    .free_vec  (free_vec),
    .resv_vec  (resv_vec),
    .saved_vec (saved_vec)
  );

endmodule

// File: rtl/tcn_checker.sv
module tcn_checker #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int ADDR_W    = 32,
  parameter int DEPTH_W   = 3,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    begin_valid,
  input logic                    end_valid,
  input logic                    abort_valid,
  input logic                    ren_valid,
  input logic                    grad_valid,
  input logic [PW-1:0]           grad_phys,
  input logic                    alloc_avail,
  input logic [PW-1:0]           alloc_phys,
  input logic [PHYS_REGS-1:0]    free_vec,
  input logic [PHYS_REGS-1:0]    resv_vec,
  input logic [PHYS_REGS-1:0]    saved_vec,
  input logic [DEPTH_W-1:0]      nest_depth,
  input logic                    redirect_valid,
  input logic                    cmd_err
);

  localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

  logic only_begin, only_end, only_abort, only_ren, only_grad;
  assign only_begin = begin_valid & ~end_valid & ~abort_valid & ~ren_valid & ~grad_valid;
  assign only_end   = end_valid & ~begin_valid & ~abort_valid & ~ren_valid & ~grad_valid;
  assign only_abort = abort_valid & ~begin_valid & ~end_valid & ~ren_valid & ~grad_valid;
  assign only_ren   = ren_valid & ~begin_valid & ~end_valid & ~abort_valid & ~grad_valid;
  assign only_grad  = grad_valid & ~begin_valid & ~end_valid & ~abort_valid & ~ren_valid;

  assert_alloc_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_avail |-> (free_vec[alloc_phys] &&
      ((free_vec & ((PHYS_REGS'(1) << alloc_phys) - PHYS_REGS'(1))) == '0)));

  assert_ren_consumes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (only_ren && alloc_avail) |=> !free_vec[$past(alloc_phys)]);

  assert_begin_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (only_begin && nest_depth != DMAX) |=> nest_depth == $past(nest_depth) + 1'b1);

  assert_inner_begin_saved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (only_begin && nest_depth != '0 && nest_depth != DMAX) |=> $stable(saved_vec));

  assert_grad_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (only_grad && saved_vec[grad_phys]) |=>
      (resv_vec[$past(grad_phys)] && !free_vec[$past(grad_phys)]));

  assert_lists_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vec & resv_vec) == '0);

  assert_commit_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (only_end && nest_depth == DEPTH_W'(1)) |=>
      (resv_vec == '0 && saved_vec == '0 && nest_depth == '0));

  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (only_abort && nest_depth != '0) |=>
      (redirect_valid && nest_depth == '0 && resv_vec == '0 && saved_vec == '0));

  assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  assert_end_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (only_end && nest_depth == '0) |=> (cmd_err && nest_depth == '0));

  assert_begin_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (only_begin && nest_depth == DMAX) |=> (cmd_err && nest_depth == DMAX));

endmodule

bind txn_ckpt_ctrl tcn_checker #(
  .ARCH_REGS(ARCH_REGS),
  .PHYS_REGS(PHYS_REGS),
  .ADDR_W   (ADDR_W),
  .DEPTH_W  (DEPTH_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .begin_valid   (begin_valid),
  .end_valid     (end_valid),
  .abort_valid   (abort_valid),
  .ren_valid     (ren_valid),
  .grad_valid    (grad_valid),
  .grad_phys     (grad_phys),
  .alloc_avail   (alloc_avail),
  .alloc_phys    (alloc_phys),
  .free_vec      (free_vec),
  .resv_vec      (resv_vec),
  .saved_vec     (saved_vec),
  .nest_depth    (nest_depth),
  .redirect_valid(redirect_valid),
  .cmd_err       (cmd_err)
);

// File: tb/test_txn_ckpt_ctrl.sv
`timescale 1ns/1ps
module test_txn_ckpt_ctrl;

  localparam int ARCH = 8;
  localparam int PHYS = 16;
  localparam int AW   = 3;
  localparam int PW   = 4;
  localparam int DW   = 3;
  localparam int DMAX = 7;

  logic            clk;
  logic            rst_n;
  logic            begin_valid;
  logic [31:0]     begin_handler;
  logic            end_valid;
  logic            abort_valid;
  logic            ren_valid;
  logic [AW-1:0]   ren_arch;
  logic            grad_valid;
  logic [PW-1:0]   grad_phys;
  logic            alloc_avail;
  logic [PW-1:0]   alloc_phys;
  logic [ARCH*PW-1:0] map_flat;
  logic [PHYS-1:0] free_vec;
  logic [PHYS-1:0] resv_vec;
  logic [PHYS-1:0] saved_vec;
  logic [DW-1:0]   nest_depth;
  logic            redirect_valid;
  logic [31:0]     redirect_pc;
  logic            cmd_err;

  txn_ckpt_ctrl i_txn_ckpt_ctrl (
    .clk(clk), .rst_n(rst_n),
    .begin_valid(begin_valid), .begin_handler(begin_handler),
    .end_valid(end_valid), .abort_valid(abort_valid),
    .ren_valid(ren_valid), .ren_arch(ren_arch),
    .grad_valid(grad_valid), .grad_phys(grad_phys),
    .alloc_avail(alloc_avail), .alloc_phys(alloc_phys),
    .map_flat(map_flat), .free_vec(free_vec), .resv_vec(resv_vec),
    .saved_vec(saved_vec), .nest_depth(nest_depth),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cmd_err(cmd_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model state
  int          m_map  [ARCH];
  int          m_snap [ARCH];
  logic [PHYS-1:0] m_free, m_resv, m_saved, m_pend;
  int          m_depth;
  logic [31:0] m_hand;
  bit          m_redir, m_err;

  function automatic logic [PHYS-1:0] map_mask(bit use_snap);
    logic [PHYS-1:0] r = '0;
    for (int i = 0; i < ARCH; i++) r[use_snap ? m_snap[i] : m_map[i]] = 1'b1;
    return r;
  endfunction

  function automatic int lowest(logic [PHYS-1:0] v);
    for (int i = 0; i < PHYS; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [ARCH*PW-1:0] em;
    for (int i = 0; i < ARCH; i++) em[i*PW +: PW] = PW'(m_map[i]);
    chk(tag, "depth", 64'(nest_depth), 64'(m_depth));
    chk(tag, "free", 64'(free_vec), 64'(m_free));
    chk(tag, "reserved", 64'(resv_vec), 64'(m_resv));
    chk(tag, "saved", 64'(saved_vec), 64'(m_saved));
    chk(tag, "map", 64'(map_flat), 64'(em));
    chk(tag, "redirect_valid", 64'(redirect_valid), 64'(m_redir));
    if (m_redir) chk(tag, "redirect_pc", 64'(redirect_pc), 64'(m_hand));
    chk(tag, "cmd_err", 64'(cmd_err), 64'(m_err));
  endtask

  task automatic clear_inputs();
    begin_valid = 0; begin_handler = '0; end_valid = 0; abort_valid = 0;
    ren_valid = 0; ren_arch = '0; grad_valid = 0; grad_phys = '0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    #1;
    clear_inputs();
    compare_all(tag);
  endtask

  task automatic do_idle();
    m_redir = 0; m_err = 0;
    step("R7");
  endtask

  task automatic do_begin(logic [31:0] h);
    string tag;
    m_redir = 0; m_err = 0;
    if (m_depth == DMAX) begin
      m_err = 1; tag = "R8";
    end else begin
      if (m_depth == 0) begin
        m_hand = h;
        for (int i = 0; i < ARCH; i++) m_snap[i] = m_map[i];
        m_saved = map_mask(0);
        tag = "R3";
      end else tag = "R4";
      m_depth++;
    end
    begin_valid = 1; begin_handler = h;
    step(tag);
  endtask

  task automatic do_end();
    string tag;
    m_redir = 0; m_err = 0;
    if (m_depth == 0) begin
      m_err = 1; tag = "R8";
    end else begin
      if (m_depth == 1) begin
        m_free = m_free | m_resv; m_resv = '0; m_saved = '0;
      end
      m_depth--; tag = "R6";
    end
    end_valid = 1;
    step(tag);
  endtask

  task automatic do_abort();
    string tag;
    m_redir = 0; m_err = 0;
    if (m_depth == 0) begin
      m_err = 1; tag = "R8";
    end else begin
      for (int i = 0; i < ARCH; i++) m_map[i] = m_snap[i];
      m_free = ~map_mask(1); m_resv = '0; m_saved = '0; m_pend = '0;
      m_depth = 0; m_redir = 1; tag = "R7";
    end
    abort_valid = 1;
    step(tag);
  endtask

  task automatic do_ren(int a);
    int p;
    m_redir = 0; m_err = 0;
    p = lowest(m_free);
    chk("R2", "alloc_avail", 64'(alloc_avail), 64'(p >= 0));
    if (p >= 0) begin
      chk("R2", "alloc_phys", 64'(alloc_phys), 64'(p));
      m_free[p] = 1'b0;
      m_pend[m_map[a]] = 1'b1;
      m_map[a] = p;
    end
    ren_valid = 1; ren_arch = AW'(a);
    step("R2");
  endtask

  task automatic do_grad(int p);
    m_redir = 0; m_err = 0;
    m_pend[p] = 1'b0;
    if (m_saved[p]) m_resv[p] = 1'b1;
    else            m_free[p] = 1'b1;
    grad_valid = 1; grad_phys = PW'(p);
    step("R5");
  endtask

  function automatic int pick_pend();
    int s = int'($urandom_range(PHYS - 1));
    for (int k = 0; k < PHYS; k++) if (m_pend[(s + k) % PHYS]) return (s + k) % PHYS;
    return -1;
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_inputs();
    rst_n = 0;
    for (int i = 0; i < ARCH; i++) begin m_map[i] = i; m_snap[i] = i; end
    m_free = {PHYS{1'b1}} << ARCH; m_resv = '0; m_saved = '0; m_pend = '0;
    m_depth = 0; m_hand = '0; m_redir = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 compare_all("R1");

    // Ignored commands outside a transaction
    do_end();
    do_abort();
    do_idle();

    // Commit path through one inner level
    do_ren(0);
    do_begin(32'h0000_1000);
    do_ren(1);                       // overwrites phys 1 (saved)
    do_grad(1);                      // saved -> reserved
    do_begin(32'h0000_2000);         // inner: handler kept
    do_ren(1);                       // overwrites txn-allocated reg
    do_grad(lowest(m_pend & ~m_saved) >= 0 ? lowest(m_pend & ~m_saved) : pick_pend());
    do_end();                        // inner end
    do_end();                        // outermost: reserved released

    // Abort path with restore
    do_begin(32'hCAFE_0040);
    do_ren(2); do_ren(3);
    do_grad(2);
    do_abort();
    do_idle();                       // redirect gone

    // Depth saturation
    for (int i = 0; i < DMAX; i++) do_begin(32'h100 + 32'(i));
    do_begin(32'hDEAD_0000);
    do_abort();

    // Free list exhaustion
    for (int i = 0; i < PHYS; i++) do_ren(i % ARCH);
    while (m_pend != '0) do_grad(pick_pend());

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99));
      if (r < 30) do_ren(int'($urandom_range(ARCH - 1)));
      else if (r < 55) begin
        int p = pick_pend();
        if (p >= 0) do_grad(p); else do_idle();
      end
      else if (r < 68) do_begin($urandom());
      else if (r < 82) do_end();
      else if (r < 88) do_abort();
      else do_idle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule